// File: doc/BRIEF.md
# Alignment Reference Window Latch

This block sets a common zero point for a local frame counter from a shared alignment pulse that every card in a system receives. It runs in the sample clock domain. The pulse comes in asynchronous to that clock. It is resynchronised, and only its rising edge is used. An arm command opens a timed window. The first pulse edge inside that window latches the value the frame counter held at that moment and restarts the counter from zero. This gives every card the same boundary.

There are two modes. In single-shot mode the zero point is set once and later pulses do nothing, so the sample stream stays continuous. In periodic mode each later pulse re-anchors the counter, provided it arrives within a tolerance band around the expected frame boundary. Every re-anchor raises a one-cycle epoch strobe. An early or late re-anchor that is still inside the band is counted as a slip. A window that times out, a pulse that arrives while nothing is armed, and a periodic pulse outside the band each raise a failure flag with a reason code.

Top module: `align_window_latch`

## Requirements
- R1: While reset is high and in the cycle after it, `frame_idx` is 0, `latched_idx` is 0, `align_done`, `align_fail`, `epoch_mark` and `slip_flag` are 0, `fail_reason` is 0 and `slip_count` is 0.
- R2: `frame_idx` advances by one per clock and wraps from FRAME_LEN-1 to 0. An accepted pulse loads 0 into it for the cycle after the accepting edge.
- R3: The pulse passes two synchroniser flops, and only a rising edge counts. A pulse first sampled high at clock edge N is acted on at edge N+2. A level held high for many cycles counts as one event.
- R4: A one-cycle `arm` clears `align_done`, `align_fail`, `fail_reason` and `slip_flag`, loads the timeout and opens the window. The first edge in the window copies the current `frame_idx` into `latched_idx`, sets `align_done`, re-anchors the counter and pulses `epoch_mark` for one cycle.
- R5: If no edge is accepted by arm edge + `timeout_cycles` + 1, the window closes with `align_fail`=1, `fail_reason`=1 and `align_done`=0.
- R6: A pulse edge while no window is open and nothing is locked sets `align_fail`=1 with `fail_reason`=2. It does not re-anchor and does not emit an epoch.
- R7: Once locked with `periodic_en`=0, pulses change neither `frame_idx`, `latched_idx`, `epoch_mark` nor the flags.
- R8: Once locked with `periodic_en`=1, an edge is accepted when the counter's next value lies within PERMIT_TOL of zero, counted circularly. An accepted edge updates `latched_idx`, re-anchors the counter and pulses `epoch_mark`.
- R9: In periodic lock, an edge outside that band sets `align_fail`=1 with `fail_reason`=3. `align_done` stays 1 and the counter keeps free-running.
- R10: A periodic re-anchor at a `frame_idx` other than FRAME_LEN-1 sets `slip_flag` (cleared by `arm`) and increments `slip_count`. `slip_count` saturates and is cleared only by reset. The first lock after arm never counts as a slip.
- R11: After `arm`, either `align_done` or `align_fail` is high within `timeout_cycles`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle request to open the alignment window |
| align_pulse | input | 1 | Shared alignment pulse, asynchronous |
| timeout_cycles | input | TMO_W | Window length in cycles, minus one |
| periodic_en | input | 1 | 1 = periodic re-anchoring, 0 = single-shot |
| frame_idx | output | $clog2(FRAME_LEN) | Re-anchored frame counter |
| latched_idx | output | $clog2(FRAME_LEN) | Counter value captured at the last accepted edge |
| align_done | output | 1 | Locked to the reference |
| align_fail | output | 1 | Failure seen since the last arm |
| fail_reason | output | 2 | 0 none, 1 timeout, 2 pulse while not armed, 3 pulse outside permitted band |
| epoch_mark | output | 1 | One-cycle strobe on each re-anchor |
| slip_flag | output | 1 | Off-schedule periodic re-anchor seen since arm |
| slip_count | output | SLIP_W | Saturating count of slips |

## Verification
The bench places pulses at chosen counter values, so the latched index, the exact cycle of the epoch strobe and the zero restart are all predicted in advance. A design with an extra or missing synchroniser stage would latch a value off by one and strobe a cycle early or late. The timeout is checked on both sides of the last accepting edge, which catches an off-by-one window. In single-shot lock the bench sends late pulses, and in periodic lock it sends pulses outside the band; a design that re-anchors on these breaks the counter's continuity, which the bench sees on `frame_idx`. A long held pulse would produce repeated epochs in a design that detects level rather than edge. Pulses at the band edges and exactly on schedule separate true slips from on-time re-anchors.

// File: rtl/align_win_pkg.sv
package align_win_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOCKED = 2'd2
  } win_state_t;

  typedef enum logic [1:0] {
    RSN_NONE    = 2'd0,
    RSN_TIMEOUT = 2'd1,
    RSN_UNARMED = 2'd2,
    RSN_OUTSIDE = 2'd3
  } fail_rsn_t;
endpackage

// File: rtl/align_pulse_sync.sv
module align_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  // Rising edge of the synchronised level
  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/align_frame_ctr.sv
module align_frame_ctr #(
  parameter int FRAME_LEN  = 16,
  parameter int PERMIT_TOL = 2,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reanchor,
  output logic [CW-1:0] cnt,
  output logic          on_time,
  output logic          in_permit
);
  localparam logic [CW-1:0] LAST_V = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] TOL_V  = CW'(PERMIT_TOL);
  localparam logic [CW-1:0] HI_V   = CW'(FRAME_LEN - PERMIT_TOL);

  logic [CW-1:0] nxt;

  assign nxt       = (cnt == LAST_V) ? '0 : cnt + 1'b1;
  assign on_time   = (cnt == LAST_V);
  assign in_permit = (nxt <= TOL_V) || ((PERMIT_TOL > 0) && (nxt >= HI_V));

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (reanchor) cnt <= '0;
    else               cnt <= nxt;
  end
endmodule

// File: rtl/align_win_fsm.sv
module align_win_fsm
  import align_win_pkg::*;
#(
  parameter int CW     = 4,
  parameter int TMO_W  = 12,
  parameter int SLIP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              edge_in,
  input  logic [TMO_W-1:0]  timeout_cycles,
  input  logic              periodic_en,
  input  logic [CW-1:0]     cnt,
  input  logic              on_time,
  input  logic              in_permit,
  output logic              accept,
  output logic [CW-1:0]     latched_idx,
  output logic              align_done,
  output logic              align_fail,
  output logic [1:0]        fail_reason,
  output logic              epoch_mark,
  output logic              slip_flag,
  output logic [SLIP_W-1:0] slip_count
);
  win_state_t       state_q;
  fail_rsn_t        rsn_q;
  logic [TMO_W-1:0] timer_q;

  assign accept = edge_in && !arm &&
                  ((state_q == ST_ARMED) ||
                   (state_q == ST_LOCKED && periodic_en && in_permit));
  assign fail_reason = rsn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rsn_q       <= RSN_NONE;
      timer_q     <= '0;
      latched_idx <= '0;
      align_done  <= 1'b0;
      align_fail  <= 1'b0;
      epoch_mark  <= 1'b0;
      slip_flag   <= 1'b0;
      slip_count  <= '0;
    end else begin
      epoch_mark <= accept;
      if (arm) begin
        state_q    <= ST_ARMED;
        timer_q    <= timeout_cycles;
        align_done <= 1'b0;
        align_fail <= 1'b0;
        rsn_q      <= RSN_NONE;
        slip_flag  <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (edge_in) begin
              align_fail <= 1'b1;
              rsn_q      <= RSN_UNARMED;
            end
          end
          ST_ARMED: begin
            if (edge_in) begin
              state_q     <= ST_LOCKED;
              align_done  <= 1'b1;
              latched_idx <= cnt;
            end else if (timer_q == '0) begin
              state_q    <= ST_IDLE;
              align_fail <= 1'b1;
              rsn_q      <= RSN_TIMEOUT;
            end else begin
              timer_q <= timer_q - 1'b1;
            end
          end
          ST_LOCKED: begin
            if (edge_in && periodic_en) begin
              if (in_permit) begin
                latched_idx <= cnt;
                if (!on_time) begin
                  slip_flag <= 1'b1;
                  if (slip_count != '1) slip_count <= slip_count + 1'b1;
                end
              end else begin
                align_fail <= 1'b1;
                rsn_q      <= RSN_OUTSIDE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/align_window_latch.sv
module align_window_latch #(
  parameter int FRAME_LEN   = 16,
  parameter int PERMIT_TOL  = 2,
  parameter int TMO_W       = 12,
  parameter int SLIP_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              align_pulse,
  input  logic [TMO_W-1:0]  timeout_cycles,
  input  logic              periodic_en,
  output logic [CW-1:0]     frame_idx,
  output logic [CW-1:0]     latched_idx,
  output logic              align_done,
  output logic              align_fail,
  output logic [1:0]        fail_reason,
  output logic              epoch_mark,
  output logic              slip_flag,
  output logic [SLIP_W-1:0] slip_count
);
  logic pulse_rise;
  logic accept;
  logic on_time;
  logic in_permit;

  align_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (align_pulse),
    .rise (pulse_rise)
  );

  align_frame_ctr #(.FRAME_LEN(FRAME_LEN), .PERMIT_TOL(PERMIT_TOL)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .reanchor  (accept),
    .cnt       (frame_idx),
    .on_time   (on_time),
    .in_permit (in_permit)
  );

  align_win_fsm #(.CW(CW), .TMO_W(TMO_W), .SLIP_W(SLIP_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .arm            (arm),
    .edge_in        (pulse_rise),
    .timeout_cycles (timeout_cycles),
    .periodic_en    (periodic_en),
    .cnt            (frame_idx),
    .on_time        (on_time),
    .in_permit      (in_permit),
    .accept         (accept),
    .latched_idx    (latched_idx),
    .align_done     (align_done),
    .align_fail     (align_fail),
    .fail_reason    (fail_reason),
    .epoch_mark     (epoch_mark),
    .slip_flag      (slip_flag),
    .slip_count     (slip_count)
  );
endmodule

// File: rtl/align_window_latch_chk.sv
module align_window_latch_chk #(
  parameter int FRAME_LEN = 16,
  parameter int TMO_W     = 12,
  parameter int SLIP_W    = 8,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input logic              clk,
  input logic              rst,
  input logic              arm,
  input logic [TMO_W-1:0]  timeout_cycles,
  input logic              periodic_en,
  input logic [CW-1:0]     frame_idx,
  input logic [CW-1:0]     latched_idx,
  input logic              align_done,
  input logic              align_fail,
  input logic [1:0]        fail_reason,
  input logic              epoch_mark,
  input logic [SLIP_W-1:0] slip_count
);
  localparam logic [CW-1:0] LAST_V = CW'(FRAME_LEN - 1);

  logic           waiting_q;
  logic [TMO_W:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting_q <= 1'b0;
      wait_q    <= '0;
    end else if (arm) begin
      waiting_q <= 1'b1;
      wait_q    <= '0;
    end else if (waiting_q && !(align_done || align_fail)) begin
      wait_q <= wait_q + 1'b1;
    end else begin
      waiting_q <= 1'b0;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (frame_idx == '0 && !align_done && !align_fail && !epoch_mark && slip_count == '0));

  assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_idx != LAST_V) |=> (frame_idx == CW'($past(frame_idx) + 1'b1) || epoch_mark));

  assert_idx_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_idx == LAST_V) |=> (frame_idx == '0));

  assert_epoch_zero_R4: assert property (@(posedge clk) disable iff (rst)
    epoch_mark |-> (frame_idx == '0 && align_done));

  assert_done_clean_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(align_done) |-> !align_fail);

  assert_fail_has_reason_R5: assert property (@(posedge clk) disable iff (rst)
    align_fail |-> (fail_reason != 2'd0));

  assert_unarmed_not_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (fail_reason == 2'd2) |-> !align_done);

  assert_single_shot_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (align_done && !periodic_en && !arm) |=> (!epoch_mark && $stable(latched_idx)));

  assert_outside_only_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (fail_reason == 2'd3) |-> align_done);

  assert_slip_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slip_count >= $past(slip_count)));

  assert_bounded_wait_R11: assert property (@(posedge clk) disable iff (rst)
    waiting_q |-> (wait_q <= ((TMO_W+1)'(timeout_cycles) + 1'b1)));
endmodule

bind align_window_latch align_window_latch_chk #(
  .FRAME_LEN (FRAME_LEN),
  .TMO_W     (TMO_W),
  .SLIP_W    (SLIP_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .arm            (arm),
  .timeout_cycles (timeout_cycles),
  .periodic_en    (periodic_en),
  .frame_idx      (frame_idx),
  .latched_idx    (latched_idx),
  .align_done     (align_done),
  .align_fail     (align_fail),
  .fail_reason    (fail_reason),
  .epoch_mark     (epoch_mark),
  .slip_count     (slip_count)
);

// File: tb/align_window_latch_test.sv
module align_window_latch_test;
  localparam int FL     = 16;
  localparam int TOL    = 2;
  localparam int TMO_W  = 12;
  localparam int SLIP_W = 8;
  localparam int CW     = $clog2(FL);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              arm = 1'b0;
  logic              align_pulse = 1'b0;
  logic [TMO_W-1:0]  timeout_cycles = '0;
  logic              periodic_en = 1'b0;
  logic [CW-1:0]     frame_idx;
  logic [CW-1:0]     latched_idx;
  logic              align_done;
  logic              align_fail;
  logic [1:0]        fail_reason;
  logic              epoch_mark;
  logic              slip_flag;
  logic [SLIP_W-1:0] slip_count;

  always #10 clk = ~clk;

  align_window_latch #(
    .FRAME_LEN(FL), .PERMIT_TOL(TOL), .TMO_W(TMO_W), .SLIP_W(SLIP_W), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .arm(arm), .align_pulse(align_pulse),
    .timeout_cycles(timeout_cycles), .periodic_en(periodic_en),
    .frame_idx(frame_idx), .latched_idx(latched_idx), .align_done(align_done),
    .align_fail(align_fail), .fail_reason(fail_reason), .epoch_mark(epoch_mark),
    .slip_flag(slip_flag), .slip_count(slip_count)
  );

  int vectors = 0;
  int miscompares = 0;
  int exp_slips = 0;

  typedef struct { int lat; int slips; } exp_t;
  exp_t sb_q[$];

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: every epoch strobe must match the next queued expectation (R4, R8, R10)
  always @(negedge clk) begin
    if (!rst && epoch_mark) begin
      if (sb_q.size() == 0) begin
        check("R7/R9 unexpected epoch", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R4/R8 latched_idx", int'(latched_idx), e.lat);
        check("R2 reanchor to zero", int'(frame_idx), 0);
        check("R10 slip_count", int'(slip_count), e.slips);
      end
    end
  end

  task automatic do_arm(input int tmo, input bit per);
    @(negedge clk);
    timeout_cycles = TMO_W'(tmo);
    periodic_en = per;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // Driver: place a rising pulse edge so the accepting clock edge sees frame_idx == tgt
  task automatic pulse_at(input int tgt, input bit acc, input bit slip, input bit hold);
    int pre;
    exp_t e;
    pre = (tgt + FL - 2) % FL;
    do @(negedge clk); while (int'(frame_idx) != pre);
    align_pulse = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (acc) begin
      if (slip) exp_slips++;
      e.lat = tgt;
      e.slips = exp_slips;
      sb_q.push_back(e);
    end
    if (!hold) align_pulse = 1'b0;
    @(negedge clk);
    check("R3 epoch on edge N+2", int'(epoch_mark), int'(acc));
  endtask

  initial begin
    #(20 * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 frame_idx", int'(frame_idx), 0);
    check("R1 align_done", int'(align_done), 0);
    check("R1 align_fail", int'(align_fail), 0);
    check("R1 fail_reason", int'(fail_reason), 0);
    check("R1 slip_flag", int'(slip_flag), 0);
    check("R1 slip_count", int'(slip_count), 0);
    // R2 free-running with wrap
    for (int i = 0; i < 20; i++) begin
      prev = int'(frame_idx);
      @(negedge clk);
      check("R2 count step", int'(frame_idx), (prev + 1) % FL);
    end
    // R6 pulse while never armed
    pulse_at(6, 1'b0, 1'b0, 1'b0);
    check("R6 fail", int'(align_fail), 1);
    check("R6 reason", int'(fail_reason), 2);
    check("R6 no reanchor", int'(frame_idx), 7);
    // R4 single-shot lock
    do_arm(40, 1'b0);
    check("R4 fail cleared", int'(align_fail), 0);
    check("R4 reason cleared", int'(fail_reason), 0);
    check("R4 not yet done", int'(align_done), 0);
    pulse_at(7, 1'b1, 1'b0, 1'b0);
    check("R4 done", int'(align_done), 1);
    // R7 later pulse ignored in single-shot
    pulse_at(9, 1'b0, 1'b0, 1'b0);
    check("R7 counter continuous", int'(frame_idx), 10);
    check("R7 latched frozen", int'(latched_idx), 7);
    check("R7 no fail", int'(align_fail), 0);
    // R5 and R11 timeout with T=5: fail appears after arm edge + 6
    @(negedge clk);
    timeout_cycles = TMO_W'(5);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    check("R4 done cleared", int'(align_done), 0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 5) check("R5 still open at T", int'(align_fail), 0);
    end
    check("R5 fail after T+1", int'(align_fail), 1);
    check("R5 reason timeout", int'(fail_reason), 1);
    check("R11 done low on timeout", int'(align_done), 0);
    // R6 late pulse after window closed
    pulse_at(3, 1'b0, 1'b0, 1'b0);
    check("R6 late reason", int'(fail_reason), 2);
    check("R6 late no lock", int'(align_done), 0);
    // R8 periodic mode, first lock is not a slip
    do_arm(100, 1'b1);
    pulse_at(4, 1'b1, 1'b0, 1'b0);
    check("R10 first lock no slip", int'(slip_flag), 0);
    pulse_at(15, 1'b1, 1'b0, 1'b0);
    check("R10 on-time no slip", int'(slip_flag), 0);
    check("R8 latched on-time", int'(latched_idx), 15);
    pulse_at(13, 1'b1, 1'b1, 1'b0);
    check("R10 early slip flag", int'(slip_flag), 1);
    pulse_at(1, 1'b1, 1'b1, 1'b0);
    check("R10 late slip count", int'(slip_count), 2);
    // R9 outside permit band
    pulse_at(8, 1'b0, 1'b0, 1'b0);
    check("R9 fail", int'(align_fail), 1);
    check("R9 reason", int'(fail_reason), 3);
    check("R9 still done", int'(align_done), 1);
    check("R9 counter continuous", int'(frame_idx), 9);
    check("R9 latched kept", int'(latched_idx), 1);
    // R3 held level is one event; R10 arm clears flag but not count
    do_arm(100, 1'b1);
    check("R10 flag cleared by arm", int'(slip_flag), 0);
    check("R10 count kept", int'(slip_count), 2);
    pulse_at(5, 1'b1, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check("R3 single event for held level", int'(frame_idx), 4);
    align_pulse = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 scoreboard drained", sb_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule